// File: doc/BRIEF.md
# Block Memory Move Engine

This block copies a run of bytes from one region of a 24-bit byte-addressed memory space to another. A caller supplies two bank bytes (destination first, source second), three 16-bit registers (source index, destination index and a count holding one less than the number of bytes), the current program counter and a direction. A one-cycle start pulse captures all of these, and the engine then walks the run one byte at a time over a simple synchronous memory port.

Every byte takes three cycles: a read at the source address, a hold cycle in which the returned byte is latched, and a write of that byte at the destination address. After each write both indices step by one, up in ascending mode and down in descending mode, wrapping modulo 65536, and the count drops by one. The byte written while the count was zero ends the move. The count then reads 0xFFFF, the program counter has advanced by three, and a one-cycle done strobe marks the point where the final register values can be taken. At start the destination bank is also copied into a data bank register.

Top module: `blkmove_engine`

## Requirements
- R1: Every write cycle addresses bits 23:16 from the destination bank byte and bits 15:0 from the current destination index (Y).
- R2: Every read cycle addresses bits 23:16 from the source bank byte and bits 15:0 from the current source index (X).
- R3: A move started with count value C makes exactly C+1 writes. done_o is high for exactly one cycle, the cycle after the last write, and at that point cnt_o reads 0xFFFF.
- R4: With dir_desc_i = 0 (ascending), X and Y each rise by one after every byte and wrap from 0xFFFF to 0x0000.
- R5: With dir_desc_i = 1 (descending), X and Y each fall by one after every byte and wrap from 0x0000 to 0xFFFF.
- R6: Each byte is one read cycle (mem_valid_o=1, mem_we_o=0), then one idle cycle, then one write cycle (mem_valid_o=1, mem_we_o=1) whose data is the byte returned for that read. The memory returns read data in the cycle after the read cycle.
- R7: From the start pulse onward, dbr_o holds the destination bank byte.
- R8: pc_o holds the captured program counter for the whole move and equals that value plus 3 when done_o is high.
- R9: A start pulse while busy_o is high has no effect: the running move completes with its original operands, and no new move follows.
- R10: After reset busy_o, done_o and mem_valid_o are low.
- R11: The bank bytes do not change during a move, so every write carries the same bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a move; sampled only when idle |
| dir_desc_i | input | 1 | 0 = ascending, 1 = descending |
| dst_bank_i | input | 8 | Destination bank byte (first operand byte) |
| src_bank_i | input | 8 | Source bank byte (second operand byte) |
| x_i | input | 16 | Initial source index |
| y_i | input | 16 | Initial destination index |
| cnt_i | input | 16 | Byte total minus one |
| pc_i | input | 16 | Program counter at the move instruction |
| mem_addr_o | output | 24 | Memory address |
| mem_valid_o | output | 1 | Memory cycle request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle completion strobe |
| x_o | output | 16 | Current source index |
| y_o | output | 16 | Current destination index |
| cnt_o | output | 16 | Current count |
| pc_o | output | 16 | Program counter |
| dbr_o | output | 8 | Data bank register |

## Verification
The bench builds the engine with its default widths: 8-bit banks, 16-bit indices and count, and a step of 3. At these widths the index wrap at both ends of a bank can be reached in a few bytes, by starting at 0xFFFE or 0x0001. A one-byte move (count 0) and overlapping ascending regions inside one bank are covered, and the bench's reference copy makes the overlap visible as propagated data. A start pulse with altered operands is injected in the middle of a move to show that it is dropped.

// File: rtl/blkmove_pkg.sv
// Shared types of the block move engine.
package blkmove_pkg;
    // Per-byte sequence: read, hold (latch returned data), write.
    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_HOLD  = 2'd2,
        MV_WRITE = 2'd3
    } mv_state_e;
endpackage

// File: rtl/blkmove_ctrl.sv
// Sequencer of the move engine. Walks each byte through read, hold and
// write, and returns to idle after the write made while the count was zero.
// Assumes: cnt_zero_i reflects the count as it stands before the step that
// goes with the current write.
module blkmove_ctrl
    import blkmove_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      cnt_zero_i,
    output mv_state_e state_o,
    output logic      load_o,
    output logic      step_o,
    output logic      done_o
);
    mv_state_e state_q, state_d;

    // Next-state selection for the per-byte sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            MV_IDLE:  if (start_i) state_d = MV_READ;
            MV_READ:  state_d = MV_HOLD;
            MV_HOLD:  state_d = MV_WRITE;
            MV_WRITE: state_d = cnt_zero_i ? MV_IDLE : MV_READ;
            default:  state_d = MV_IDLE;
        endcase
    end

    // State register and the registered completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MV_IDLE;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_o  <= (state_q == MV_WRITE) && cnt_zero_i;
        end
    end

    assign state_o = state_q;
    assign load_o  = (state_q == MV_IDLE) && start_i;
    assign step_o  = (state_q == MV_WRITE);
endmodule

// File: rtl/blkmove_regs.sv
// Architectural registers of the move: indices, count, program counter,
// data bank register and the captured source bank and direction.
// Assumes: load_i and step_i are never high together.
module blkmove_regs #(
    parameter int BANK_W  = 8,
    parameter int IDX_W   = 16,
    parameter int PC_W    = 16,
    parameter int PC_STEP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              desc_i,
    input  logic [BANK_W-1:0] dst_bank_i,
    input  logic [BANK_W-1:0] src_bank_i,
    input  logic [IDX_W-1:0]  x_i,
    input  logic [IDX_W-1:0]  y_i,
    input  logic [IDX_W-1:0]  cnt_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [IDX_W-1:0]  x_o,
    output logic [IDX_W-1:0]  y_o,
    output logic [IDX_W-1:0]  cnt_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [BANK_W-1:0] dbr_o,
    output logic [BANK_W-1:0] src_bank_o,
    output logic              cnt_zero_o
);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
    localparam logic [PC_W-1:0]  PC_INC  = PC_W'(PC_STEP);

    logic             desc_q;
    logic [IDX_W-1:0] x_next, y_next;

    // Index stepping; a parameterless choice between adder and subtractor.
    always_comb begin
        x_next = desc_q ? (x_o - IDX_ONE) : (x_o + IDX_ONE);
        y_next = desc_q ? (y_o - IDX_ONE) : (y_o + IDX_ONE);
    end

    // Capture operands at start; step indices, count and PC per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o        <= '0;
            y_o        <= '0;
            cnt_o      <= '0;
            pc_o       <= '0;
            dbr_o      <= '0;
            src_bank_o <= '0;
            desc_q     <= 1'b0;
        end else if (load_i) begin
            x_o        <= x_i;
            y_o        <= y_i;
            cnt_o      <= cnt_i;
            pc_o       <= pc_i;
            dbr_o      <= dst_bank_i;
            src_bank_o <= src_bank_i;
            desc_q     <= desc_i;
        end else if (step_i) begin
            x_o   <= x_next;
            y_o   <= y_next;
            cnt_o <= cnt_o - IDX_ONE;
            if (cnt_zero_o) pc_o <= pc_o + PC_INC;
        end
    end

    assign cnt_zero_o = (cnt_o == '0);
endmodule

// File: rtl/blkmove_port.sv
// Memory-side datapath: forms bank:index addresses for the read and the
// write of each byte and latches the returned byte during the hold cycle.
// Assumes: the memory answers a read one cycle after the read request.
module blkmove_port
    import blkmove_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int IDX_W  = 16,
    parameter int DATA_W = 8,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mv_state_e         state_i,
    input  logic [BANK_W-1:0] src_bank_i,
    input  logic [BANK_W-1:0] dst_bank_i,
    input  logic [IDX_W-1:0]  x_i,
    input  logic [IDX_W-1:0]  y_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              we_o,
    output logic [DATA_W-1:0] wdata_o
);
    logic [DATA_W-1:0] data_q;

    // Latch the byte the memory returns during the hold cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (state_i == MV_HOLD) data_q <= rdata_i;
    end

    // Drive address and strobes for the read and write cycles.
    always_comb begin
        addr_o  = '0;
        valid_o = 1'b0;
        we_o    = 1'b0;
        case (state_i)
            MV_READ: begin
                addr_o  = {src_bank_i, x_i};
                valid_o = 1'b1;
            end
            MV_WRITE: begin
                addr_o  = {dst_bank_i, y_i};
                valid_o = 1'b1;
                we_o    = 1'b1;
            end
            default: ;
        endcase
    end

    assign wdata_o = data_q;
endmodule

// File: rtl/blkmove_engine.sv
// Top of the block move engine. Copies cnt_i+1 bytes from {src_bank_i, X}
// to {dst_bank_i, Y}, stepping both indices up or down, then advances the
// program counter and strobes done_o.
// Assumes: a single-port synchronous memory with one-cycle read latency.
module blkmove_engine #(
    parameter int BANK_W  = 8,
    parameter int IDX_W   = 16,
    parameter int DATA_W  = 8,
    parameter int PC_W    = 16,
    parameter int PC_STEP = 3,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_desc_i,
    input  logic [BANK_W-1:0] dst_bank_i,
    input  logic [BANK_W-1:0] src_bank_i,
    input  logic [IDX_W-1:0]  x_i,
    input  logic [IDX_W-1:0]  y_i,
    input  logic [IDX_W-1:0]  cnt_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_valid_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  x_o,
    output logic [IDX_W-1:0]  y_o,
    output logic [IDX_W-1:0]  cnt_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [BANK_W-1:0] dbr_o
);
    import blkmove_pkg::*;

    mv_state_e         state;
    logic              load, step, cnt_zero;
    logic [BANK_W-1:0] src_bank;

    blkmove_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cnt_zero_i (cnt_zero),
        .state_o    (state),
        .load_o     (load),
        .step_o     (step),
        .done_o     (done_o)
    );

    blkmove_regs #(
        .BANK_W  (BANK_W),
        .IDX_W   (IDX_W),
        .PC_W    (PC_W),
        .PC_STEP (PC_STEP)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .desc_i     (dir_desc_i),
        .dst_bank_i (dst_bank_i),
        .src_bank_i (src_bank_i),
        .x_i        (x_i),
        .y_i        (y_i),
        .cnt_i      (cnt_i),
        .pc_i       (pc_i),
        .x_o        (x_o),
        .y_o        (y_o),
        .cnt_o      (cnt_o),
        .pc_o       (pc_o),
        .dbr_o      (dbr_o),
        .src_bank_o (src_bank),
        .cnt_zero_o (cnt_zero)
    );

    blkmove_port #(
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .src_bank_i (src_bank),
        .dst_bank_i (dbr_o),
        .x_i        (x_o),
        .y_i        (y_o),
        .rdata_i    (mem_rdata_i),
        .addr_o     (mem_addr_o),
        .valid_o    (mem_valid_o),
        .we_o       (mem_we_o),
        .wdata_o    (mem_wdata_o)
    );

    assign busy_o = (state != MV_IDLE);
endmodule

// File: rtl/blkmove_engine_chk.sv
// Temporal checks on the ports of the move engine, bound to its top.
module blkmove_engine_chk #(
    parameter int BANK_W = 8,
    parameter int IDX_W  = 16,
    parameter int DATA_W = 8,
    parameter int PC_W   = 16,
    parameter int PC_STEP = 3,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_valid_o,
    input logic              mem_we_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [IDX_W-1:0]  cnt_o,
    input logic [PC_W-1:0]   pc_o,
    input logic [BANK_W-1:0] dbr_o
);
    // R10: no memory traffic while idle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_valid_o);

    // R6: a read is followed by a gap cycle and then a write.
    p_rd_gap_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_we_o) |=> (!mem_valid_o ##1 (mem_valid_o && mem_we_o)));

    // R6: the written byte is the one returned in the previous cycle.
    p_wdata_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_we_o) |-> (mem_wdata_o == $past(mem_rdata_i)));

    // R3: done is a single-cycle strobe.
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: count reads all-ones at completion.
    p_cnt_final_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cnt_o == {IDX_W{1'b1}}));

    // R8: the program counter holds while a move runs.
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (done_o || $stable(pc_o)));

    // R8: the program counter steps by the fixed amount at completion.
    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pc_o == $past(pc_o) + PC_W'(PC_STEP)));

    // R1/R11: writes carry the destination bank held in the data bank register.
    p_wr_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_we_o) |-> (mem_addr_o[ADDR_W-1:IDX_W] == dbr_o));
endmodule

bind blkmove_engine blkmove_engine_chk #(
    .BANK_W  (BANK_W),
    .IDX_W   (IDX_W),
    .DATA_W  (DATA_W),
    .PC_W    (PC_W),
    .PC_STEP (PC_STEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cnt_o       (cnt_o),
    .pc_o        (pc_o),
    .dbr_o       (dbr_o)
);

// File: tb/tb_blkmove_engine.sv
// Scoreboard bench: the driver computes the expected reads and writes from a
// reference copy and queues them; the monitor pops and compares them.
module tb_blkmove_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_desc_i = 1'b0;
    logic [7:0]  dst_bank_i = '0, src_bank_i = '0;
    logic [15:0] x_i = '0, y_i = '0, cnt_i = '0, pc_i = '0;
    logic [23:0] mem_addr_o;
    logic        mem_valid_o, mem_we_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        busy_o, done_o;
    logic [15:0] x_o, y_o, cnt_o, pc_o;
    logic [7:0]  dbr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    longint cyc = 0;
    longint rd_cyc = 0;

    logic [7:0]  dmem [logic [23:0]];
    logic [7:0]  rmem [logic [23:0]];
    logic [23:0] exp_rd_q [$];
    logic [31:0] exp_wr_q [$];

    always #10 clk = ~clk;   // 50 MHz

    blkmove_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_desc_i(dir_desc_i),
        .dst_bank_i(dst_bank_i), .src_bank_i(src_bank_i), .x_i(x_i), .y_i(y_i),
        .cnt_i(cnt_i), .pc_i(pc_i), .mem_addr_o(mem_addr_o),
        .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .x_o(x_o), .y_o(y_o),
        .cnt_o(cnt_o), .pc_o(pc_o), .dbr_o(dbr_o)
    );

    function automatic logic [7:0] seed_byte(input logic [23:0] a);
        return a[7:0] ^ {a[12:8], 3'b101} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] dmem_rd(input logic [23:0] a);
        return dmem.exists(a) ? dmem[a] : seed_byte(a);
    endfunction

    function automatic logic [7:0] rmem_rd(input logic [23:0] a);
        return rmem.exists(a) ? rmem[a] : seed_byte(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: one-cycle read latency, write on the clock edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_valid_o) begin
            if (mem_we_o) dmem[mem_addr_o] = mem_wdata_o;
            else          mem_rdata_i <= dmem_rd(mem_addr_o);
        end
    end

    // Monitor: compare memory cycles against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && mem_valid_o && !mem_we_o) begin
            if (exp_rd_q.size() == 0) check(1'b0, "R2 unexpected read", {8'h0, mem_addr_o}, 32'h0);
            else begin
                logic [23:0] ea;
                ea = exp_rd_q.pop_front();
                check(mem_addr_o == ea, "R2 read address", {8'h0, mem_addr_o}, {8'h0, ea});
            end
            rd_cyc = cyc;
        end
        if (rst_n && mem_valid_o && mem_we_o) begin
            if (exp_wr_q.size() == 0) check(1'b0, "R3 extra write", {mem_addr_o, mem_wdata_o}, 32'h0);
            else begin
                logic [31:0] ew;
                ew = exp_wr_q.pop_front();
                check({mem_addr_o, mem_wdata_o} == ew, "R1/R6 write address and data",
                      {mem_addr_o, mem_wdata_o}, ew);
            end
            check(cyc - rd_cyc == 2, "R6 write two cycles after read",
                  32'(cyc - rd_cyc), 32'd2);
        end
    end

    // Driver: queue expectations, launch a move, check final state.
    task automatic run_move(input bit desc, input logic [7:0] db, input logic [7:0] sb,
                            input logic [15:0] x0, input logic [15:0] y0,
                            input logic [15:0] c0, input logic [15:0] p0, input bit poke);
        logic [15:0] x = x0;
        logic [15:0] y = y0;
        int guard = 0;
        for (int i = 0; i <= int'(c0); i++) begin
            logic [7:0] d;
            d = rmem_rd({sb, x});
            rmem[{db, y}] = d;
            exp_rd_q.push_back({sb, x});
            exp_wr_q.push_back({db, y, d});
            x = desc ? x - 16'd1 : x + 16'd1;
            y = desc ? y - 16'd1 : y + 16'd1;
        end
        @(negedge clk);
        dir_desc_i = desc; dst_bank_i = db; src_bank_i = sb;
        x_i = x0; y_i = y0; cnt_i = c0; pc_i = p0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dir_desc_i = ~desc; dst_bank_i = ~db; src_bank_i = ~sb;
        x_i = 16'h1234; y_i = 16'h4321; cnt_i = 16'h0007; pc_i = 16'hBEEF;
        check(dbr_o == db, "R7 data bank loaded at start", {24'h0, dbr_o}, {24'h0, db});
        check(pc_o == p0, "R8 pc held during move", {16'h0, pc_o}, {16'h0, p0});
        if (poke) begin
            start_i = 1'b1;    // R9: must be ignored while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(done_o, "R3 done seen", {31'h0, done_o}, 32'h1);
        check(cnt_o == 16'hFFFF, "R3 final count", {16'h0, cnt_o}, 32'hFFFF);
        check(exp_wr_q.size() == 0, "R3 all writes made", exp_wr_q.size(), 32'h0);
        check(x_o == x, desc ? "R5 final X" : "R4 final X", {16'h0, x_o}, {16'h0, x});
        check(y_o == y, desc ? "R5 final Y" : "R4 final Y", {16'h0, y_o}, {16'h0, y});
        check(pc_o == p0 + 16'd3, "R8 pc advanced by 3", {16'h0, pc_o}, {16'h0, p0 + 16'd3});
        check(dbr_o == db, "R7 data bank at end", {24'h0, dbr_o}, {24'h0, db});
        @(negedge clk);
        check(!done_o, "R3 done lasts one cycle", {31'h0, done_o}, 32'h0);
        @(negedge clk);
        check(!busy_o, "R9 no move follows ignored start", {31'h0, busy_o}, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !mem_valid_o, "R10 reset state",
              {29'h0, busy_o, done_o, mem_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !mem_valid_o, "R10 idle after reset",
              {30'h0, busy_o, mem_valid_o}, 32'h0);
        // R4 plain ascending move across banks, five bytes
        run_move(1'b0, 8'h12, 8'h34, 16'h1000, 16'h2000, 16'd4, 16'h0400, 1'b0);
        // R5 descending with index wrap below zero
        run_move(1'b1, 8'h7E, 8'h01, 16'h0001, 16'h0000, 16'd3, 16'h8000, 1'b0);
        // R4 ascending with wrap above 0xFFFF
        run_move(1'b0, 8'h03, 8'hC0, 16'hFFFE, 16'hFFFF, 16'd2, 16'hFFFE, 1'b0);
        // R3 single byte (count zero)
        run_move(1'b0, 8'h55, 8'hAA, 16'h0100, 16'h0200, 16'd0, 16'h1111, 1'b0);
        // R6 overlapping ascending regions in one bank propagate the first byte
        run_move(1'b0, 8'h20, 8'h20, 16'h0300, 16'h0301, 16'd5, 16'h2222, 1'b0);
        // R9 start pulse injected mid-move; R11 banks unchanged
        run_move(1'b1, 8'h44, 8'h66, 16'h0050, 16'h0090, 16'd6, 16'h3333, 1'b1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule